// File: doc/BRIEF.md
# Writeback Result Selector with Sub-Word Load Alignment

This block sits at the end of the execute stage of a simple 32-bit RISC datapath. It picks the value that goes back to the register file and drives the matching write strobe. The candidate values are:

- the adder/subtractor output;
- the logic-unit output;
- operand A after a small fixed shift;
- data returned by memory, narrowed and extended for the load size;
- the incremented program counter, which call instructions save.

A 4-bit select code from the decoder names the source. The block registers its result, so the value and the strobe appear one clock after the inputs.

The shifter covers only distances 1, 2 and 4, either left or right. Wider shifts are meant to be composed by repeating the instruction. The load aligner takes a byte or halfword from any lane of the 32-bit memory word. It then fills the upper bits with the sign bit or with zeros. On the first cycle of a store, the store data (carried on operand A) travels along the result path so it can reach the bus. The write strobe stays low on that cycle, so the register file is not disturbed.

Top module: `wb_result_sel`

## Requirements
- R1: While `rst` is high at a rising edge, `wb_data` becomes 0 and `wb_en` becomes 0.
- R2: Code 0 returns `add_res` and code 1 returns `logic_res`, both with `wb_en` = 1.
- R3: Codes 2, 3 and 4 return `opnd_a` shifted left by 1, 2 and 4, with zeros entering at bit 0, and `wb_en` = 1.
- R4: Codes 5, 6 and 7 return `opnd_a` shifted right by 1, 2 and 4, with zeros entering at bit 31 (logical), and `wb_en` = 1.
- R5: For byte loads, `addr_lo` value k selects `mem_rdata[8k+7:8k]` (little-endian, so k = 3 takes bits [31:24]) into bits [7:0]. Code 8 copies bit 7 into bits [31:8]; code 9 clears bits [31:8]. Both set `wb_en` = 1.
- R6: For halfword loads, `addr_lo[1]` = 0 selects `mem_rdata[15:0]` and 1 selects `mem_rdata[31:16]`, with `addr_lo[0]` having no effect. Code 10 copies bit 15 into bits [31:16]; code 11 clears them. Both set `wb_en` = 1.
- R7: Code 12 (word load) returns `mem_rdata` unchanged for every `addr_lo`, with `wb_en` = 1.
- R8: Code 13 (link) returns `next_pc` with `wb_en` = 1.
- R9: Code 14 (store cycle) places `opnd_a` unchanged on `wb_data` while `wb_en` = 0.
- R10: Code 15 is unused: `wb_data` = 0 and `wb_en` = 0.
- R11: Outputs change only at a rising edge, and reflect the inputs present at that edge, giving a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 4 | Source select code (see R2–R10) |
| add_res | input | DATA_W (32) | Adder/subtractor output |
| logic_res | input | DATA_W (32) | Logic-unit output |
| opnd_a | input | DATA_W (32) | Operand A; shift source and store data |
| mem_rdata | input | DATA_W (32) | Word returned by memory |
| addr_lo | input | LANE_W (2) | Low bits of the load byte address |
| next_pc | input | DATA_W (32) | Incremented program counter for calls |
| wb_data | output | DATA_W (32) | Registered writeback value |
| wb_en | output | 1 | Registered register-file write strobe |

## Verification
The clocked properties assume that every input holds a defined value at each rising edge once reset has dropped. Each property compares the output against the inputs from exactly one edge earlier. They are armed only after one full cycle outside reset, because the output register holds its cleared value until then. The bench keeps within this assumption by driving all inputs on falling edges from a single process. It leaves no input floating at any edge. It also walks every select code against every `addr_lo` value over a fixed set of data words. The set includes both sign-bit polarities in every lane.

// File: rtl/wb_sel_pkg.sv
package wb_sel_pkg;

    // Select codes presented by the decoder
    typedef enum logic [3:0] {
        SEL_ADD   = 4'd0,
        SEL_LOGIC = 4'd1,
        SEL_SHL1  = 4'd2,
        SEL_SHL2  = 4'd3,
        SEL_SHL4  = 4'd4,
        SEL_SHR1  = 4'd5,
        SEL_SHR2  = 4'd6,
        SEL_SHR4  = 4'd7,
        SEL_LDB   = 4'd8,
        SEL_LDBU  = 4'd9,
        SEL_LDH   = 4'd10,
        SEL_LDHU  = 4'd11,
        SEL_LDW   = 4'd12,
        SEL_LINK  = 4'd13,
        SEL_STORE = 4'd14,
        SEL_NONE  = 4'd15
    } wb_sel_e;

    // Internal source of the final multiplexer
    typedef enum logic [2:0] {
        SRC_ADD,
        SRC_LOGIC,
        SRC_SHIFT,
        SRC_LOAD,
        SRC_LINK,
        SRC_OPA,
        SRC_ZERO
    } wb_src_e;

    typedef enum logic [1:0] {
        SH_BY1,
        SH_BY2,
        SH_BY4
    } sh_amt_e;

    typedef enum logic [1:0] {
        LD_BYTE,
        LD_HALF,
        LD_WORD
    } ld_size_e;

    typedef struct packed {
        wb_src_e  src;
        logic     sh_right;
        sh_amt_e  sh_amt;
        ld_size_e ld_size;
        logic     ld_signed;
        logic     wen;
    } wb_ctrl_t;

    function automatic wb_ctrl_t decode_sel(input logic [3:0] code);
        wb_ctrl_t c;
        c.src       = SRC_ZERO;
        c.sh_right  = 1'b0;
        c.sh_amt    = SH_BY1;
        c.ld_size   = LD_WORD;
        c.ld_signed = 1'b0;
        c.wen       = 1'b1;
        case (code)
            SEL_ADD:   c.src = SRC_ADD;
            SEL_LOGIC: c.src = SRC_LOGIC;
            SEL_SHL1:  begin c.src = SRC_SHIFT; c.sh_amt = SH_BY1; end
            SEL_SHL2:  begin c.src = SRC_SHIFT; c.sh_amt = SH_BY2; end
            SEL_SHL4:  begin c.src = SRC_SHIFT; c.sh_amt = SH_BY4; end
            SEL_SHR1:  begin c.src = SRC_SHIFT; c.sh_right = 1'b1; c.sh_amt = SH_BY1; end
            SEL_SHR2:  begin c.src = SRC_SHIFT; c.sh_right = 1'b1; c.sh_amt = SH_BY2; end
            SEL_SHR4:  begin c.src = SRC_SHIFT; c.sh_right = 1'b1; c.sh_amt = SH_BY4; end
            SEL_LDB:   begin c.src = SRC_LOAD; c.ld_size = LD_BYTE; c.ld_signed = 1'b1; end
            SEL_LDBU:  begin c.src = SRC_LOAD; c.ld_size = LD_BYTE; end
            SEL_LDH:   begin c.src = SRC_LOAD; c.ld_size = LD_HALF; c.ld_signed = 1'b1; end
            SEL_LDHU:  begin c.src = SRC_LOAD; c.ld_size = LD_HALF; end
            SEL_LDW:   c.src = SRC_LOAD;
            SEL_LINK:  c.src = SRC_LINK;
            SEL_STORE: begin c.src = SRC_OPA; c.wen = 1'b0; end
            default:   begin c.src = SRC_ZERO; c.wen = 1'b0; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/wb_shifter.sv
module wb_shifter
    import wb_sel_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    input  logic              right,
    input  sh_amt_e           amt,
    output logic [DATA_W-1:0] dout
);
    localparam int NDIST = 3;  // distances 1, 2, 4

    logic [DATA_W-1:0] to_left  [NDIST];
    logic [DATA_W-1:0] to_right [NDIST];

    for (genvar k = 0; k < NDIST; k++) begin : g_dist
        assign to_left[k]  = din << (1 << k);
        assign to_right[k] = din >> (1 << k);
    end

    always_comb begin
        case (amt)
            SH_BY1:  dout = right ? to_right[0] : to_left[0];
            SH_BY2:  dout = right ? to_right[1] : to_left[1];
            SH_BY4:  dout = right ? to_right[2] : to_left[2];
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/wb_load_align.sv
module wb_load_align
    import wb_sel_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int LANE_W = $clog2(DATA_W / 8)
) (
    input  logic [DATA_W-1:0] mem,
    input  logic [LANE_W-1:0] addr_lo,
    input  ld_size_e          size,
    input  logic              sign_ext,
    output logic [DATA_W-1:0] dout
);
    localparam int NBYTES = DATA_W / 8;
    localparam int NHALF  = DATA_W / 16;

    logic [7:0]  byte_lane [NBYTES];
    logic [15:0] half_lane [NHALF];

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign byte_lane[b] = mem[b*8 +: 8];
    end
    for (genvar h = 0; h < NHALF; h++) begin : g_half
        assign half_lane[h] = mem[h*16 +: 16];
    end

    logic [7:0]  byte_pick;
    logic [15:0] half_pick;

    assign byte_pick = byte_lane[addr_lo];
    assign half_pick = half_lane[addr_lo[LANE_W-1:1]];

    always_comb begin
        case (size)
            LD_BYTE: dout = {{(DATA_W-8){sign_ext & byte_pick[7]}}, byte_pick};
            LD_HALF: dout = {{(DATA_W-16){sign_ext & half_pick[15]}}, half_pick};
            default: dout = mem;
        endcase
    end
endmodule

// File: rtl/wb_result_sel.sv
module wb_result_sel
    import wb_sel_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int LANE_W = $clog2(DATA_W / 8)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        sel,
    input  logic [DATA_W-1:0] add_res,
    input  logic [DATA_W-1:0] logic_res,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [LANE_W-1:0] addr_lo,
    input  logic [DATA_W-1:0] next_pc,
    output logic [DATA_W-1:0] wb_data,
    output logic              wb_en
);
    wb_ctrl_t          ctrl;
    logic [DATA_W-1:0] shift_val;
    logic [DATA_W-1:0] load_val;
    logic [DATA_W-1:0] result_d;
    logic              live_q;

    assign ctrl = decode_sel(sel);

    wb_shifter #(.DATA_W(DATA_W)) u_shift (
        .din   (opnd_a),
        .right (ctrl.sh_right),
        .amt   (ctrl.sh_amt),
        .dout  (shift_val)
    );

    wb_load_align #(.DATA_W(DATA_W)) u_align (
        .mem      (mem_rdata),
        .addr_lo  (addr_lo),
        .size     (ctrl.ld_size),
        .sign_ext (ctrl.ld_signed),
        .dout     (load_val)
    );

    always_comb begin
        case (ctrl.src)
            SRC_ADD:   result_d = add_res;
            SRC_LOGIC: result_d = logic_res;
            SRC_SHIFT: result_d = shift_val;
            SRC_LOAD:  result_d = load_val;
            SRC_LINK:  result_d = next_pc;
            SRC_OPA:   result_d = opnd_a;
            default:   result_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_data <= '0;
            wb_en   <= 1'b0;
            live_q  <= 1'b0;
        end else begin
            wb_data <= result_d;
            wb_en   <= ctrl.wen;
            live_q  <= 1'b1;
        end
    end

    // Checks compare outputs against inputs from the previous edge
    assert_store_no_write_R9: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(sel) == SEL_STORE) |-> (!wb_en && wb_data == $past(opnd_a)))
        else $error("store cycle wrote back or lost data");

    assert_unused_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(sel) == SEL_NONE) |-> (!wb_en && wb_data == '0))
        else $error("unused code produced output");

    assert_link_pc_R8: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(sel) == SEL_LINK) |-> (wb_en && wb_data == $past(next_pc)))
        else $error("link did not save next pc");

    assert_word_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(sel) == SEL_LDW) |-> (wb_data == $past(mem_rdata)))
        else $error("word load altered data");

    assert_byte_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(sel) == SEL_LDBU) |-> (wb_data[DATA_W-1:8] == '0))
        else $error("unsigned byte has upper bits set");

    assert_byte_sign_R5: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(sel) == SEL_LDB) |-> (wb_data[DATA_W-1:8] == {(DATA_W-8){wb_data[7]}}))
        else $error("signed byte not extended");

    assert_half_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(sel) == SEL_LDHU) |-> (wb_data[DATA_W-1:16] == '0))
        else $error("unsigned half has upper bits set");

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (!wb_en && wb_data == '0))
        else $error("reset did not clear outputs");
endmodule

// File: tb/tb_wb_result_sel.sv
module tb_wb_result_sel;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  sel;
    logic [31:0] add_res, logic_res, opnd_a, mem_rdata, next_pc;
    logic [1:0]  addr_lo;
    logic [31:0] wb_data;
    logic        wb_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;  // 50 MHz

    wb_result_sel dut (
        .clk(clk), .rst(rst), .sel(sel), .add_res(add_res), .logic_res(logic_res),
        .opnd_a(opnd_a), .mem_rdata(mem_rdata), .addr_lo(addr_lo), .next_pc(next_pc),
        .wb_data(wb_data), .wb_en(wb_en)
    );

    task automatic check(input string tag, input logic [31:0] act_d, input logic act_e,
                         input logic [31:0] exp_d, input logic exp_e);
        n_tests++;
        if (act_d !== exp_d || act_e !== exp_e) begin
            n_fail++;
            $display("FAIL %s: got data=%h en=%b, expected data=%h en=%b",
                     tag, act_d, act_e, exp_d, exp_e);
        end
    endtask

    function automatic string tag_of(input int code);
        if (code <= 1)  return "R2";
        if (code <= 4)  return "R3";
        if (code <= 7)  return "R4";
        if (code <= 9)  return "R5";
        if (code <= 11) return "R6";
        if (code == 12) return "R7";
        if (code == 13) return "R8";
        if (code == 14) return "R9";
        return "R10";
    endfunction

    // Independent arithmetic model of the requirements
    function automatic logic [32:0] model(input int code, input logic [31:0] a, lg, op,
                                          mem, pc, input int adr);
        logic [31:0] v, part;
        v = 0;
        case (code)
            0: v = a;
            1: v = lg;
            2: v = op * 2;
            3: v = op * 4;
            4: v = op * 16;
            5: v = op / 2;
            6: v = op / 4;
            7: v = op / 16;
            8, 9: begin
                part = (mem >> (8 * adr)) & 32'hFF;
                v = (code == 8 && part >= 32'h80) ? (part | 32'hFFFF_FF00) : part;
            end
            10, 11: begin
                part = (mem >> (16 * (adr / 2))) & 32'hFFFF;
                v = (code == 10 && part >= 32'h8000) ? (part | 32'hFFFF_0000) : part;
            end
            12: v = mem;
            13: v = pc;
            14: v = op;
            default: v = 0;
        endcase
        return {(code < 14), v};
    endfunction

    function automatic logic [31:0] mix(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed, corner[4];
        logic [32:0] e;
        corner[0] = 32'h0000_0000;
        corner[1] = 32'hFFFF_FFFF;
        corner[2] = 32'h8080_8080;
        corner[3] = 32'h7F7F_7F7F;
        seed = 32'h1234_5678;

        rst = 1'b1; sel = 4'd13; addr_lo = 2'd3;
        add_res = 32'hDEAD_BEEF; logic_res = 32'h1; opnd_a = 32'h2;
        mem_rdata = 32'h3; next_pc = 32'hCAFE_0004;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", wb_data, wb_en, 32'h0, 1'b0);
        rst = 1'b0;

        // R11: output unchanged before the edge, updated after it
        sel = 4'd13; next_pc = 32'h0000_1000;
        #2 check("R11 before edge", wb_data, wb_en, 32'h0, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R11 after edge", wb_data, wb_en, 32'h0000_1000, 1'b1);
        sel = 4'd0; add_res = 32'h5555_0000;
        #2 check("R11 held", wb_data, wb_en, 32'h0000_1000, 1'b1);

        for (int p = 0; p < 24; p++) begin
            logic [31:0] a, lg, op, mem, pc;
            seed = mix(seed); a   = seed;
            seed = mix(seed); lg  = seed;
            seed = mix(seed); op  = (p < 4) ? corner[p] : seed;
            seed = mix(seed); mem = (p < 4) ? corner[p] : ((p < 8) ? corner[p-4] ^ seed & 32'h0101_0101 : seed);
            seed = mix(seed); pc  = seed & 32'hFFFF_FFFC;
            for (int code = 0; code < 16; code++) begin
                for (int adr = 0; adr < 4; adr++) begin
                    sel = code[3:0]; addr_lo = adr[1:0];
                    add_res = a; logic_res = lg; opnd_a = op; mem_rdata = mem; next_pc = pc;
                    e = model(code, a, lg, op, mem, pc, adr);
                    @(posedge clk); @(negedge clk);
                    check(tag_of(code), wb_data, wb_en, e[31:0], e[32]);
                end
            end
        end

        // R1: reset mid-stream clears a live value
        sel = 4'd13; next_pc = 32'hFFFF_0000; rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 reset midstream", wb_data, wb_en, 32'h0, 1'b0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule